// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs on the host side of a link to a 12-bit successive-approximation converter with a serial output. A one-cycle start request opens a frame. The block then drives the select and frame-sync lines and generates the serial clock. It shifts in sixteen bits, most significant first, and keeps the twelve leading bits as an unsigned straight-binary result: 000h is zero scale and FFFh is full scale minus one LSB. A one-cycle valid strobe flags the new result. The serial clock idles low. The converter changes its data on rising edges, so the controller samples on falling edges.

There are two framing modes, chosen at the start request. In select framing, the frame-sync line stays high and the falling edge of the active-low select begins the frame. In sync framing, the select line is pulled low and frame-sync is held high for one serial-clock period. Frame-sync falls together with an SCLK falling edge, and the next sixteen falling edges carry the data.

After the last bit the select line goes high, and one more full SCLK period runs so the converter sees a falling edge while deselected. Busy is released only after that period.

The controller is a four-state machine. IDLE moves to SHIFT (select framing) or to LEAD (sync framing) on an accepted start. LEAD moves to SHIFT on its SCLK falling edge ("lead done"). SHIFT moves to TAIL on the sixteenth falling edge ("last bit"). TAIL moves back to IDLE on its own falling edge ("tail done").

Top module: `adc_rd_ctrl`

## Requirements
- R1: In select framing, `cs_n_o` falls in the cycle after an accepted start, and `fs_o` stays at 1 for the whole frame and while idle afterwards.
- R2: In sync framing, `cs_n_o` goes low and `fs_o` goes high together and stay so for exactly one SCLK period. `fs_o` then falls in the same cycle as an SCLK falling edge, and idles at 0 afterwards.
- R3: Exactly 16 SCLK falling edges with `cs_n_o` low carry data after the frame start. Bits are taken most significant first, one per falling edge, in the cycle where `sclk_o` falls.
- R4: `result_o` equals bits 15..4 of the received 16-bit word. Bits 3..0 have no effect on it.
- R5: The SCLK period is P = max(`div_i`, 4) system clocks. Each period has P/2 (rounded down) low cycles followed by the remaining high cycles.
- R6: `valid_o` is high for exactly one cycle, the cycle after the sixteenth sampling edge, with `busy_o` still high and `cs_n_o` already high.
- R7: After the data, `cs_n_o` is high for one full SCLK period that ends in a falling edge. `busy_o` falls in the same cycle as that edge. Busy lasts 17·P cycles in select framing and 18·P in sync framing.
- R8: A start request while `busy_o` is high is ignored: no new frame follows, and `busy_o` stays low after the current frame ends.
- R9: `div_i` and `mode_fs_i` are sampled only at an accepted start. Changing them mid-frame leaves that frame unchanged.
- R10: After reset, `busy_o`, `valid_o` and `sclk_o` are 0, `cs_n_o` and `fs_o` are 1, and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| mode_fs_i | input | 1 | 1: sync framing, 0: select framing |
| div_i | input | DIV_W (8) | System clocks per SCLK period, clamped to at least 4 |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle strobe, new result |
| result_o | output | RES_BITS (12) | Unsigned conversion result |
| cs_n_o | output | 1 | Converter select, active low |
| fs_o | output | 1 | Frame-sync line |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_i | input | 1 | Serial data from the converter |

## Verification
Two events can land in the same cycle: the valid strobe or the final tail falling edge, and a new start request. The bench raises `start_i` in exactly the cycle where `valid_o` is seen high. In a separate frame it raises `start_i` in the last busy cycle, where the TAIL edge ends the frame. In both cases the request must be dropped. The result must still match the word the converter model sent, and `busy_o` must stay low in the cycles after the frame, with no second select falling edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } rd_state_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
    parameter int DIV_W   = 8,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] period_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    localparam logic [DIV_W-1:0] MIN_P = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;

    // period clamp and half-period split
    assign eff    = (period_i < MIN_P) ? MIN_P : period_i;
    assign half   = eff >> 1;
    assign rise_o = run_i && (cnt == half - 1'b1);
    assign fall_o = run_i && (cnt == eff - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sclk_o <= 1'b0;
        end else if (!run_i) begin
            cnt    <= '0;
            sclk_o <= 1'b0;
        end else if (fall_o) begin
            cnt    <= '0;
            sclk_o <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (rise_o) begin
                sclk_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                shift_i,
    input  logic                sdo_i,
    output logic [RES_BITS-1:0] res_o
);
    logic [RES_BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear_i) begin
            sh_q <= '0;
        end else if (shift_i) begin
            sh_q <= {sh_q[RES_BITS-2:0], sdo_i};
        end
    end

    assign res_o = sh_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
    parameter int DIV_W      = 8,
    parameter int MIN_DIV    = 4,
    parameter int FRAME_BITS = 16,
    parameter int RES_BITS   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mode_fs_i,
    input  logic [DIV_W-1:0]    div_i,
    output logic                busy_o,
    output logic                valid_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                cs_n_o,
    output logic                fs_o,
    output logic                sclk_o,
    input  logic                sdo_i
);
    import adc_rd_pkg::*;

    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] KEEP_END = CNT_W'(RES_BITS);

    rd_state_t        state, nxt;
    logic             mode_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             run;
    logic             sck_rise;
    logic             sck_fall;
    logic             accept;
    logic             sample;
    logic             last;
    logic [RES_BITS-1:0] sh_res;

    assign accept = (state == ST_IDLE) && start_i;
    assign run    = (state != ST_IDLE);
    assign sample = (state == ST_SHIFT) && sck_fall;
    assign last   = sample && (bit_cnt == LAST_BIT);

    adc_rd_sclk_gen #(
        .DIV_W   (DIV_W),
        .MIN_DIV (MIN_DIV)
    ) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .period_i (div_q),
        .sclk_o   (sclk_o),
        .rise_o   (sck_rise),
        .fall_o   (sck_fall)
    );

    adc_rd_shifter #(
        .RES_BITS (RES_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .shift_i (sample && (bit_cnt < KEEP_END)),
        .sdo_i   (sdo_i),
        .res_o   (sh_res)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_i)  nxt = mode_fs_i ? ST_LEAD : ST_SHIFT;
            ST_LEAD:  if (sck_fall) nxt = ST_SHIFT;
            ST_SHIFT: if (last)     nxt = ST_TAIL;
            ST_TAIL:  if (sck_fall) nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // frame settings, bit counter, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            div_q    <= DIV_W'(MIN_DIV);
            bit_cnt  <= '0;
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= last;
            if (accept) begin
                mode_q  <= mode_fs_i;
                div_q   <= div_i;
                bit_cnt <= '0;
            end else if (sample) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (last) begin
                result_o <= sh_res;
            end
        end
    end

    // pin outputs
    always_comb begin
        busy_o = 1'b1;
        cs_n_o = 1'b0;
        fs_o   = !mode_q;
        unique case (state)
            ST_IDLE: begin
                busy_o = 1'b0;
                cs_n_o = 1'b1;
            end
            ST_LEAD:  fs_o = 1'b1;
            ST_SHIFT: fs_o = !mode_q;
            ST_TAIL:  cs_n_o = 1'b1;
            default: begin
                busy_o = 1'b0;
                cs_n_o = 1'b1;
            end
        endcase
    end

    logic unused_rise;
    assign unused_rise = sck_rise;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic valid_o,
    input logic cs_n_o,
    input logic fs_o,
    input logic sclk_o
);
    // R6: strobe lasts one cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: strobe only after deselect while still busy
    a_r6_valid_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (busy_o && cs_n_o));

    // R10: quiet pins when idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && cs_n_o));

    // R2: frame-sync rises only with the converter selected
    a_r2_fs_rise_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_o) |-> !cs_n_o);

    // R2: frame-sync falls within a frame only with an SCLK falling edge
    a_r2_fs_fall_on_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fs_o) && !cs_n_o) |-> $fell(sclk_o));

    // R8: a frame opens only from idle on a request
    a_r8_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(!busy_o && start_i));

    // R7: busy ends together with the tail falling edge, deselected
    a_r7_busy_end_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($fell(sclk_o) && cs_n_o));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .cs_n_o  (cs_n_o),
    .fs_o    (fs_o),
    .sclk_o  (sclk_o)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_fs_i = 1'b0;
    logic [7:0]  div_i = 8'd4;
    logic        busy_o, valid_o, cs_n_o, fs_o, sclk_o;
    logic [11:0] result_o;
    logic        sdo_i = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    adc_rd_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_fs_i (mode_fs_i),
        .div_i     (div_i),
        .busy_o    (busy_o),
        .valid_o   (valid_o),
        .result_o  (result_o),
        .cs_n_o    (cs_n_o),
        .fs_o      (fs_o),
        .sclk_o    (sclk_o),
        .sdo_i     (sdo_i)
    );

    // converter model: data changes after SCLK rises, MSB at frame start
    logic [15:0] dev_word = 16'h0;
    int          dev_k = 0;
    logic        d_sclk = 1'b0, d_cs = 1'b1, d_fs = 1'b1;

    always @(negedge clk) begin
        if (d_cs && !cs_n_o) begin
            dev_k = 0;
            sdo_i = dev_word[15];
        end else if (d_fs && !fs_o && !cs_n_o) begin
            dev_k = 0;
        end else if (d_sclk && !sclk_o) begin
            dev_k = dev_k + 1;
        end
        if (!d_sclk && sclk_o) begin
            sdo_i = (dev_k < 16) ? dev_word[15 - dev_k] : 1'b0;
        end
        d_sclk = sclk_o;
        d_cs   = cs_n_o;
        d_fs   = fs_o;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // frame statistics
    int st_busy, st_frame_falls, st_tail_falls, st_valid_n, st_valid_idx;
    int st_valid_bad, st_res, st_fs_hi, st_fs_low_busy, st_min_gap, st_max_gap;
    int st_high, st_first_cs, st_first_fs, st_post_busy, st_fs_fall_bad;

    task automatic run_frame(input logic [15:0] w, input bit fsm, input logic [7:0] dv,
                             input int ign_at, input bit ign_valid, input int chg_at);
        logic p_sclk, p_cs, p_fs;
        int   gap;
        int   nf;
        dev_word = w;
        st_busy = 0; st_frame_falls = 0; st_tail_falls = 0; st_valid_n = 0;
        st_valid_idx = -1; st_valid_bad = 0; st_res = -1; st_fs_hi = 0;
        st_fs_low_busy = 0; st_min_gap = 1 << 20; st_max_gap = 0; st_high = 0;
        st_post_busy = 0; st_fs_fall_bad = 0;
        gap = 0; nf = 0;
        @(negedge clk);
        mode_fs_i = fsm; div_i = dv; start_i = 1'b1;
        p_sclk = sclk_o; p_cs = cs_n_o; p_fs = fs_o;
        @(negedge clk);
        start_i = 1'b0;
        st_first_cs = cs_n_o;
        st_first_fs = fs_o;
        for (int i = 0; i < 20000; i++) begin
            start_i = 1'b0;
            gap++;
            if (busy_o) st_busy++;
            if (sclk_o) st_high++;
            if (busy_o && !fs_o) st_fs_low_busy++;
            if (fs_o && !cs_n_o) st_fs_hi++;
            if (p_fs && !fs_o && !cs_n_o && !(p_sclk && !sclk_o)) st_fs_fall_bad++;
            if (p_sclk && !sclk_o) begin
                if (!p_cs) st_frame_falls++; else st_tail_falls++;
                if (nf > 0) begin
                    if (gap < st_min_gap) st_min_gap = gap;
                    if (gap > st_max_gap) st_max_gap = gap;
                end
                nf++;
                gap = 0;
            end
            if (valid_o) begin
                st_valid_n++;
                st_valid_idx = st_busy;
                st_res = int'(result_o);
                if (!(busy_o && cs_n_o)) st_valid_bad++;
                if (ign_valid) start_i = 1'b1;
            end
            if (busy_o && st_busy == ign_at) start_i = 1'b1;
            if (st_busy == chg_at) begin
                div_i = 8'd9;
                mode_fs_i = !fsm;
            end
            p_sclk = sclk_o; p_cs = cs_n_o; p_fs = fs_o;
            if (!busy_o) break;
            @(negedge clk);
        end
        start_i = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            if (busy_o || !cs_n_o) st_post_busy++;
        end
    endtask

    task automatic check_frame(input string tag, input logic [15:0] w, input bit fsm,
                               input logic [7:0] dv);
        int p, h;
        p = (dv < 4) ? 4 : int'(dv);
        h = p / 2;
        $display("-- %s", tag);
        check("R4 result is word bits 15..4", st_res, int'(w[15:4]));
        check("R3 data falling edges with select low", st_frame_falls, fsm ? 17 : 16);
        check("R7 tail falling edges while deselected", st_tail_falls, 1);
        check("R7 busy length", st_busy, fsm ? 18 * p : 17 * p);
        check("R6 single valid strobe", st_valid_n, 1);
        check("R6 valid cycle after last sample", st_valid_idx, fsm ? 17 * p + 1 : 16 * p + 1);
        check("R6 valid with busy high and select high", st_valid_bad, 0);
        check("R5 min SCLK period", st_min_gap, p);
        check("R5 max SCLK period", st_max_gap, p);
        check("R5 high cycles", st_high, (p - h) * (fsm ? 18 : 17));
        check("R8 no frame after end", st_post_busy, 0);
        if (fsm) begin
            check("R2 select low at start", st_first_cs, 0);
            check("R2 sync high at start", st_first_fs, 1);
            check("R2 sync high for one period", st_fs_hi, p);
            check("R2 sync falls only with SCLK", st_fs_fall_bad, 0);
            check("R2 sync idles low", int'(fs_o), 0);
        end else begin
            check("R1 select low at start", st_first_cs, 0);
            check("R1 sync held high in frame", st_fs_low_busy, 0);
            check("R1 sync idles high", int'(fs_o), 1);
        end
    endtask

    task automatic t_reset();
        $display("-- reset state");
        check("R10 busy", int'(busy_o), 0);
        check("R10 valid", int'(valid_o), 0);
        check("R10 sclk", int'(sclk_o), 0);
        check("R10 cs_n", int'(cs_n_o), 1);
        check("R10 fs", int'(fs_o), 1);
        check("R10 result", int'(result_o), 0);
    endtask

    task automatic t_cs_frames();
        run_frame(16'hABCF, 1'b0, 8'd4, -1, 1'b0, -1);
        check_frame("R1 select framing div 4", 16'hABCF, 1'b0, 8'd4);
        run_frame(16'h5A5A, 1'b0, 8'd7, -1, 1'b0, -1);
        check_frame("R3 select framing div 7", 16'h5A5A, 1'b0, 8'd7);
    endtask

    task automatic t_fs_frames();
        run_frame(16'hFFF0, 1'b1, 8'd6, -1, 1'b0, -1);
        check_frame("R2 sync framing div 6 full scale", 16'hFFF0, 1'b1, 8'd6);
        run_frame(16'h000F, 1'b1, 8'd5, -1, 1'b0, -1);
        check_frame("R4 sync framing zero scale low nibble set", 16'h000F, 1'b1, 8'd5);
    endtask

    task automatic t_clamp();
        run_frame(16'h8421, 1'b0, 8'd0, -1, 1'b0, -1);
        check_frame("R5 divider 0 clamps to 4", 16'h8421, 1'b0, 8'd0);
        run_frame(16'h1248, 1'b0, 8'd2, -1, 1'b0, -1);
        check_frame("R5 divider 2 clamps to 4", 16'h1248, 1'b0, 8'd2);
    endtask

    task automatic t_ignore();
        run_frame(16'hC3C3, 1'b0, 8'd4, 5, 1'b0, -1);
        check_frame("R8 start mid-frame", 16'hC3C3, 1'b0, 8'd4);
        run_frame(16'h3C35, 1'b0, 8'd4, -1, 1'b1, -1);
        check_frame("R8 start together with valid", 16'h3C35, 1'b0, 8'd4);
        run_frame(16'h9999, 1'b1, 8'd4, 18 * 4, 1'b0, -1);
        check_frame("R8 start in last busy cycle", 16'h9999, 1'b1, 8'd4);
    endtask

    task automatic t_latch();
        run_frame(16'h7E17, 1'b0, 8'd4, -1, 1'b0, 10);
        mode_fs_i = 1'b0;
        check_frame("R9 settings changed mid-frame", 16'h7E17, 1'b0, 8'd4);
        div_i = 8'd4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_cs_frames();
        t_fs_frames();
        t_clamp();
        t_ignore();
        t_latch();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule